// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This core supervises software liveness with a countdown that runs in two chained stages, clocked from a fixed reference clock. When it is enabled, the first stage loads a length derived from its own 20-bit preload. If software does not ping the core before that stage runs out, the core emits an interrupt pulse of the configured kind. It then starts the second stage at once, using the second preload. If the second stage also runs out, the core pulses a reset request and sets a sticky status flag that records a watchdog-caused reset. In free-running mode the core then re-arms itself from the first stage.

Stage lengths are scaled by one of two prescale shifts. The slow scale shifts the preload left by 15 and the fast scale shifts it left by 5. A lock bit freezes the enable, free-run and lock settings until reset. Host bus decoding stays outside the block: register writes arrive as simple strobes with their data.

Top module: `wdt2s_top`

## Requirements
- R1: After reset there are no pulses on `irq_o`, `smi_o` or `rst_req_o`, and `prev_rst_o` is 0. The defaults are: reboot enabled, slow scale, interrupt kind 0, free-run off, unlocked and disabled. Both preloads are 0xFFFFF.
- R2: A stage lasts max(P << S, 1) clock cycles, where P is that stage's preload. S is 15 when `cfg_fast_i` was written 0 and 5 when it was written 1. A stage that starts at clock edge E expires at edge E + length, and its pulse is visible in the cycle after that edge.
- R3: A control write with `ctl_enable_i`=1 while the core is disabled starts stage 1 at that edge. A control write with `ctl_enable_i`=0 stops the countdown, and no further pulses follow.
- R4: At stage 1 expiry, interrupt kind 0 pulses `irq_o` and kind 2 pulses `smi_o`. Kinds 1 and 3 give no pulse. Stage 2 starts at the same edge, with the length of preload 2.
- R5: At stage 2 expiry with reboot enabled (`cfg_noreboot_i`=0), the core pulses `rst_req_o` and sets `prev_rst_o`. With reboot disabled it does neither.
- R6: After stage 2 expiry with free-run set, stage 1 restarts at the same edge. Without free-run the countdown stops.
- R7: `ping_i` while the core is enabled restarts stage 1 from preload 1. `ping_i` while the core is disabled has no effect.
- R8: A control write with `ctl_lock_i`=1 causes every later control write to be ignored until reset.
- R9: `prev_rst_o` stays set until `flag_clr_i` is sampled. If a set and a clear fall on the same edge, the set wins.
- R10: Each of `irq_o`, `smi_o` and `rst_req_o` is a single-cycle pulse, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_enable_i | input | 1 | Control data: enable |
| ctl_freerun_i | input | 1 | Control data: free-running mode |
| ctl_lock_i | input | 1 | Control data: lock control writes |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_noreboot_i | input | 1 | Configuration: 1 suppresses the reset request |
| cfg_fast_i | input | 1 | Configuration: 1 selects the fast scale (shift 5) |
| cfg_itype_i | input | 2 | Configuration: interrupt kind at stage 1 expiry |
| pre1_wr_i | input | 1 | Write strobe for preload 1 |
| pre2_wr_i | input | 1 | Write strobe for preload 2 |
| pre_data_i | input | 20 | Preload write data |
| ping_i | input | 1 | Keep-alive ping |
| flag_clr_i | input | 1 | Clears the previous-reset flag |
| irq_o | output | 1 | Normal interrupt pulse |
| smi_o | output | 1 | System-management interrupt pulse |
| rst_req_o | output | 1 | Reset request pulse |
| prev_rst_o | output | 1 | Sticky flag: a watchdog reset occurred |

## Verification
A wrong stage register, a stale length or a lost running bit shows up at the ports only as a pulse of the wrong kind or at the wrong cycle. The bench therefore predicts the exact edge of every pulse and matches each one, with its kind and cycle, against that prediction. A miscount is visible within one stage length, and a pulse that should not appear is reported in the cycle it is seen. The status flag is also checked before and after clears and resets, because a stuck or lost flag leaves no other trace.

// File: rtl/wdt2s_pkg.sv
package wdt2s_pkg;
  localparam int PRE_W   = 20;
  localparam int SLOW_SH = 15;
  localparam int FAST_SH = 5;

  typedef enum logic [1:0] {
    INT_IRQ  = 2'd0,
    INT_RSV  = 2'd1,
    INT_SMI  = 2'd2,
    INT_NONE = 2'd3
  } int_kind_e;

  typedef enum logic {
    STG_FIRST  = 1'b0,
    STG_SECOND = 1'b1
  } stage_e;
endpackage

// File: rtl/wdt2s_len.sv
module wdt2s_len #(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5,
  parameter int CNT_W   = PRE_W + SLOW_SH
) (
  input  logic [PRE_W-1:0] pre_i,
  input  logic             fast_i,
  output logic [CNT_W-1:0] len_o
);
  localparam int PAD_W = CNT_W - PRE_W;

  logic [CNT_W-1:0] pre_ext;

  assign pre_ext = {{PAD_W{1'b0}}, pre_i};

  always_comb begin
    if (fast_i) len_o = pre_ext << FAST_SH;
    else        len_o = pre_ext << SLOW_SH;
  end
endmodule

// File: rtl/wdt2s_ctr.sv
module wdt2s_ctr #(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (run_i & (cnt_q != '0));

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // a zero-length stage still lasts one cycle
  assign expire_o = run_i & (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/wdt2s_ctrl.sv
module wdt2s_ctrl
  import wdt2s_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic             ctl_enable_i,
  input  logic             ctl_freerun_i,
  input  logic             ctl_lock_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_noreboot_i,
  input  logic             cfg_fast_i,
  input  logic [1:0]       cfg_itype_i,
  input  logic             pre1_wr_i,
  input  logic             pre2_wr_i,
  input  logic [PRE_W-1:0] pre_data_i,
  input  logic             ping_i,
  input  logic             flag_clr_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic [PRE_W-1:0] pre_sel_o,
  output logic             fast_o,
  output logic             run_o,
  output logic             irq_o,
  output logic             smi_o,
  output logic             rst_req_o,
  output logic             prev_rst_o
);
  logic             en_q, en_d, lock_q, lock_d, frun_q, frun_d;
  logic             rbdis_q, rbdis_d, fast_q, fast_d;
  int_kind_e        ityp_q, ityp_d;
  logic [PRE_W-1:0] pre1_q, pre1_d, pre2_q, pre2_d;
  stage_e           stage_q, stage_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d, smi_q, smi_d, rq_q, rq_d;
  logic             flag_q, flag_d, flag_set;
  logic             accept, sel_second, start_first;

  always_comb begin
    accept      = ctl_wr_i & ~lock_q;
    en_d        = accept ? ctl_enable_i  : en_q;
    frun_d      = accept ? ctl_freerun_i : frun_q;
    lock_d      = accept ? ctl_lock_i    : lock_q;
    rbdis_d     = cfg_wr_i ? cfg_noreboot_i : rbdis_q;
    fast_d      = cfg_wr_i ? cfg_fast_i     : fast_q;
    ityp_d      = cfg_wr_i ? int_kind_e'(cfg_itype_i) : ityp_q;
    pre1_d      = pre1_wr_i ? pre_data_i : pre1_q;
    pre2_d      = pre2_wr_i ? pre_data_i : pre2_q;
    start_first = (accept & ctl_enable_i & ~en_q) | (ping_i & en_q);

    run_d      = run_q;
    stage_d    = stage_q;
    load_o     = 1'b0;
    sel_second = 1'b0;
    irq_d      = 1'b0;
    smi_d      = 1'b0;
    rq_d       = 1'b0;
    flag_set   = 1'b0;

    if (accept && !ctl_enable_i) begin
      run_d   = 1'b0;
      stage_d = STG_FIRST;
    end else if (start_first) begin
      load_o  = 1'b1;
      run_d   = 1'b1;
      stage_d = STG_FIRST;
    end else if (expire_i) begin
      if (stage_q == STG_FIRST) begin
        load_o     = 1'b1;
        sel_second = 1'b1;
        stage_d    = STG_SECOND;
        irq_d      = (ityp_q == INT_IRQ);
        smi_d      = (ityp_q == INT_SMI);
      end else begin
        rq_d     = ~rbdis_q;
        flag_set = ~rbdis_q;
        stage_d  = STG_FIRST;
        if (frun_q) load_o = 1'b1;
        else        run_d  = 1'b0;
      end
    end

    flag_d = flag_set | (flag_q & ~flag_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lock_q  <= 1'b0;
      frun_q  <= 1'b0;
      rbdis_q <= 1'b0;
      fast_q  <= 1'b0;
      ityp_q  <= INT_IRQ;
      pre1_q  <= '1;
      pre2_q  <= '1;
      stage_q <= STG_FIRST;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
      smi_q   <= 1'b0;
      rq_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      lock_q  <= lock_d;
      frun_q  <= frun_d;
      rbdis_q <= rbdis_d;
      fast_q  <= fast_d;
      ityp_q  <= ityp_d;
      pre1_q  <= pre1_d;
      pre2_q  <= pre2_d;
      stage_q <= stage_d;
      run_q   <= run_d;
      irq_q   <= irq_d;
      smi_q   <= smi_d;
      rq_q    <= rq_d;
      flag_q  <= flag_d;
    end
  end

  assign pre_sel_o  = sel_second ? pre2_q : pre1_q;
  assign fast_o     = fast_q;
  assign run_o      = run_q;
  assign irq_o      = irq_q;
  assign smi_o      = smi_q;
  assign rst_req_o  = rq_q;
  assign prev_rst_o = flag_q;
endmodule

// File: rtl/wdt2s_top.sv
module wdt2s_top
  import wdt2s_pkg::*;
#(
  parameter int PRE_WIDTH   = wdt2s_pkg::PRE_W,
  parameter int SLOW_SHIFT  = wdt2s_pkg::SLOW_SH,
  parameter int FAST_SHIFT  = wdt2s_pkg::FAST_SH,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr_i,
  input  logic                 ctl_enable_i,
  input  logic                 ctl_freerun_i,
  input  logic                 ctl_lock_i,
  input  logic                 cfg_wr_i,
  input  logic                 cfg_noreboot_i,
  input  logic                 cfg_fast_i,
  input  logic [1:0]           cfg_itype_i,
  input  logic                 pre1_wr_i,
  input  logic                 pre2_wr_i,
  input  logic [PRE_WIDTH-1:0] pre_data_i,
  input  logic                 ping_i,
  input  logic                 flag_clr_i,
  output logic                 irq_o,
  output logic                 smi_o,
  output logic                 rst_req_o,
  output logic                 prev_rst_o
);
  localparam int MAX_SH = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
  localparam int CNT_W  = PRE_WIDTH + MAX_SH;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[SYNC_STAGES-1];

  logic                 load, fast, run, expire;
  logic [PRE_WIDTH-1:0] pre_sel;
  logic [CNT_W-1:0]     len;

  wdt2s_ctrl #(.PRE_W(PRE_WIDTH)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .ctl_wr_i       (ctl_wr_i),
    .ctl_enable_i   (ctl_enable_i),
    .ctl_freerun_i  (ctl_freerun_i),
    .ctl_lock_i     (ctl_lock_i),
    .cfg_wr_i       (cfg_wr_i),
    .cfg_noreboot_i (cfg_noreboot_i),
    .cfg_fast_i     (cfg_fast_i),
    .cfg_itype_i    (cfg_itype_i),
    .pre1_wr_i      (pre1_wr_i),
    .pre2_wr_i      (pre2_wr_i),
    .pre_data_i     (pre_data_i),
    .ping_i         (ping_i),
    .flag_clr_i     (flag_clr_i),
    .expire_i       (expire),
    .load_o         (load),
    .pre_sel_o      (pre_sel),
    .fast_o         (fast),
    .run_o          (run),
    .irq_o          (irq_o),
    .smi_o          (smi_o),
    .rst_req_o      (rst_req_o),
    .prev_rst_o     (prev_rst_o)
  );

  wdt2s_len #(
    .PRE_W   (PRE_WIDTH),
    .SLOW_SH (SLOW_SHIFT),
    .FAST_SH (FAST_SHIFT),
    .CNT_W   (CNT_W)
  ) u_len (
    .pre_i  (pre_sel),
    .fast_i (fast),
    .len_o  (len)
  );

  wdt2s_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load),
    .load_val_i (len),
    .run_i      (run),
    .expire_o   (expire)
  );
endmodule

// File: rtl/wdt2s_chk.sv
module wdt2s_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_o,
  input logic smi_o,
  input logic rst_req_o,
  input logic prev_rst_o,
  input logic flag_clr_i
);
  a_r10_one_pulse_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_o, smi_o, rst_req_o}));

  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r10_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |=> !smi_o);

  a_r10_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  a_r5_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> prev_rst_o);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_rst_o && !flag_clr_i) |=> prev_rst_o);

  a_r9_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prev_rst_o) |-> rst_req_o);

  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i |=> (!prev_rst_o || rst_req_o));
endmodule

bind wdt2s_top wdt2s_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .smi_o      (smi_o),
  .rst_req_o  (rst_req_o),
  .prev_rst_o (prev_rst_o),
  .flag_clr_i (flag_clr_i)
);

// File: tb/test_wdt2s_top.sv
`timescale 1ns/1ps
module test_wdt2s_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr_i, ctl_enable_i, ctl_freerun_i, ctl_lock_i;
  logic        cfg_wr_i, cfg_noreboot_i, cfg_fast_i;
  logic [1:0]  cfg_itype_i;
  logic        pre1_wr_i, pre2_wr_i;
  logic [19:0] pre_data_i;
  logic        ping_i, flag_clr_i;
  logic        irq_o, smi_o, rst_req_o, prev_rst_o;

  wdt2s_top i_wdt2s_top (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_i(ctl_wr_i), .ctl_enable_i(ctl_enable_i),
    .ctl_freerun_i(ctl_freerun_i), .ctl_lock_i(ctl_lock_i),
    .cfg_wr_i(cfg_wr_i), .cfg_noreboot_i(cfg_noreboot_i),
    .cfg_fast_i(cfg_fast_i), .cfg_itype_i(cfg_itype_i),
    .pre1_wr_i(pre1_wr_i), .pre2_wr_i(pre2_wr_i), .pre_data_i(pre_data_i),
    .ping_i(ping_i), .flag_clr_i(flag_clr_i),
    .irq_o(irq_o), .smi_o(smi_o), .rst_req_o(rst_req_o), .prev_rst_o(prev_rst_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int     exp_kind[$];
  int     exp_cyc[$];
  string  exp_req[$];

  localparam int K_IRQ = 0, K_SMI = 1, K_RST = 2;

  task automatic expect_ev(input int kind, input int at, input string req);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
    exp_req.push_back(req);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic take(input int kind);
    int ek, ec;
    string er;
    pulses++;
    checks++;
    if (exp_kind.size() == 0) begin
      fails++;
      $display("FAIL R3/R6: unexpected pulse kind actual %0d expected none at cycle %0d", kind, cyc);
    end else begin
      ek = exp_kind.pop_front();
      ec = exp_cyc.pop_front();
      er = exp_req.pop_front();
      if (ek != kind || ec != cyc) begin
        fails++;
        $display("FAIL %s: pulse kind/cycle actual %0d/%0d expected %0d/%0d", er, kind, cyc, ek, ec);
      end
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n) begin
      if ((int'(irq_o) + int'(smi_o) + int'(rst_req_o)) > 1) begin
        checks++; fails++;
        $display("FAIL R10: simultaneous pulses actual %b expected at most one", {irq_o, smi_o, rst_req_o});
      end
      if (irq_o)     take(K_IRQ);
      if (smi_o)     take(K_SMI);
      if (rst_req_o) take(K_RST);
    end
  end

  // driver tasks: each returns the edge that samples the strobe
  task automatic ctl(input bit en, input bit fr, input bit lk, output int edge_n);
    @(negedge clk);
    ctl_wr_i = 1; ctl_enable_i = en; ctl_freerun_i = fr; ctl_lock_i = lk;
    edge_n = cyc + 1;
    @(negedge clk);
    ctl_wr_i = 0;
  endtask

  task automatic cfg(input bit nrb, input bit fast, input logic [1:0] ity);
    @(negedge clk);
    cfg_wr_i = 1; cfg_noreboot_i = nrb; cfg_fast_i = fast; cfg_itype_i = ity;
    @(negedge clk);
    cfg_wr_i = 0;
  endtask

  task automatic preload(input logic [19:0] p1, input logic [19:0] p2);
    @(negedge clk);
    pre1_wr_i = 1; pre_data_i = p1;
    @(negedge clk);
    pre1_wr_i = 0; pre2_wr_i = 1; pre_data_i = p2;
    @(negedge clk);
    pre2_wr_i = 0;
  endtask

  task automatic ping(output int edge_n);
    @(negedge clk);
    ping_i = 1;
    edge_n = cyc + 1;
    @(negedge clk);
    ping_i = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr_i = 1;
    @(negedge clk);
    flag_clr_i = 0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 200000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int e0, p, seen;
    rst_n = 0;
    ctl_wr_i = 0; ctl_enable_i = 0; ctl_freerun_i = 0; ctl_lock_i = 0;
    cfg_wr_i = 0; cfg_noreboot_i = 0; cfg_fast_i = 0; cfg_itype_i = 0;
    pre1_wr_i = 0; pre2_wr_i = 0; pre_data_i = 0;
    ping_i = 0; flag_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports
    check(!irq_o && !smi_o && !rst_req_o, "R1 pulses idle", int'({irq_o, smi_o, rst_req_o}), 0);
    check(prev_rst_o == 1'b0, "R1 flag after reset", int'(prev_rst_o), 0);

    // R1/R2: default slow scale and kind 0; preload 1 -> 32768 cycles
    preload(20'd1, 20'd1);
    ctl(1, 0, 0, e0);
    expect_ev(K_IRQ, e0 + 32768, "R1 default slow IRQ");
    wait_until(e0 + 32768 + 5);
    ctl(0, 0, 0, p);
    check(prev_rst_o == 1'b0, "R3 no reset after disable", int'(prev_rst_o), 0);

    // R2 fast, R4 irq, R5 reset, R6 stop without free-run
    cfg(0, 1, 2'd0);
    preload(20'd2, 20'd1);
    ctl(1, 0, 0, e0);
    expect_ev(K_IRQ, e0 + 64, "R4 irq kind 0");
    expect_ev(K_RST, e0 + 96, "R5 reset request");
    wait_until(e0 + 300);
    check(prev_rst_o == 1'b1, "R9 flag sticky", int'(prev_rst_o), 1);
    check(exp_kind.size() == 0, "R6 stop after stage 2", exp_kind.size(), 0);
    ctl(0, 0, 0, p);
    clear_flag();
    check(prev_rst_o == 1'b0, "R9 flag cleared", int'(prev_rst_o), 0);

    // R7: ping while disabled does nothing
    seen = pulses;
    ping(p);
    wait_until(p + 200);
    check(pulses == seen, "R7 ping while disabled", pulses - seen, 0);

    // R4 smi, R7 ping restart
    cfg(0, 1, 2'd2);
    ctl(1, 0, 0, e0);
    wait_until(e0 + 40);
    ping(p);
    expect_ev(K_SMI, p + 64, "R7 ping restart / R4 smi");
    expect_ev(K_RST, p + 96, "R5 reset after smi");
    wait_until(p + 120);
    ctl(0, 0, 0, e0);
    clear_flag();

    // R4 kind 3 no interrupt, R2 zero preload lasts one cycle
    cfg(0, 1, 2'd3);
    preload(20'd0, 20'd1);
    ctl(1, 0, 0, e0);
    expect_ev(K_RST, e0 + 1 + 32, "R2 zero preload / R4 kind 3");
    wait_until(e0 + 60);
    check(prev_rst_o == 1'b1, "R5 flag set", int'(prev_rst_o), 1);
    ctl(0, 0, 0, e0);
    clear_flag();

    // R4 kind 1 gives no interrupt
    cfg(0, 1, 2'd1);
    ctl(1, 0, 0, e0);
    expect_ev(K_RST, e0 + 1 + 32, "R4 kind 1 silent");
    wait_until(e0 + 60);
    ctl(0, 0, 0, e0);
    clear_flag();

    // R5 reboot disabled, R6 free-run restart
    cfg(1, 1, 2'd0);
    preload(20'd2, 20'd1);
    ctl(1, 1, 0, e0);
    expect_ev(K_IRQ, e0 + 64, "R6 first irq");
    expect_ev(K_IRQ, e0 + 160, "R6 free-run irq");
    expect_ev(K_IRQ, e0 + 256, "R6 free-run irq 2");
    wait_until(e0 + 270);
    ctl(0, 0, 0, p);
    check(prev_rst_o == 1'b0, "R5 no flag with reboot off", int'(prev_rst_o), 0);

    // R3: disable mid-stage stops all pulses
    cfg(0, 1, 2'd0);
    seen = pulses;
    ctl(1, 0, 0, e0);
    wait_until(e0 + 30);
    ctl(0, 0, 0, p);
    wait_until(e0 + 200);
    check(pulses == seen, "R3 disable stops", pulses - seen, 0);

    // R8: lock ignores later disable
    ctl(1, 0, 1, e0);
    expect_ev(K_IRQ, e0 + 64, "R8 locked irq");
    expect_ev(K_RST, e0 + 96, "R8 locked reset");
    wait_until(e0 + 10);
    ctl(0, 0, 0, p);
    wait_until(e0 + 130);
    check(prev_rst_o == 1'b1, "R8 lock kept enable", int'(prev_rst_o), 1);

    // R1: reset clears flag
    do_reset();
    check(prev_rst_o == 1'b0, "R1 flag after reset", int'(prev_rst_o), 0);
    check(exp_kind.size() == 0, "R10 all expected pulses seen", exp_kind.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule